// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides, for a single memory request, whether the access is granted or faults. It works from a small set of protection entries, each made of a configuration byte and an address register. A request carries a byte address, an access kind (read, write or instruction fetch) and a flag that is high for machine privilege and low for supervisor or user privilege. Two global flags shape the decision. The lockdown flag changes what the entry bits mean. The allowlist flag makes machine-mode accesses that match no entry fault.

Each entry matches its region in one of three ways: top-of-range, a naturally aligned four-byte word, or a naturally aligned power-of-two block. When several entries match, the lowest-numbered one alone sets the outcome. With lockdown clear, the classic rules apply. With lockdown set, the lock bit separates machine-only rules from supervisor/user-only rules. The write-without-read encoding and the all-ones encoding then describe shared regions whose rights differ by privilege.

The check itself is combinational. Its verdict is captured in one output register, so a result is visible one clock after the request is presented.

Top module: `pmpchk_top`

## Requirements
- R1: While `rst_ni` is low, `grant_o` is 0. Otherwise `grant_o` holds the verdict for the inputs present at the previous rising clock edge. Access codes on `acc_i` are 0 read, 1 write, 2 fetch. `priv_m_i` = 1 means machine privilege.
- R2: Entry i uses configuration bits [8i+7:8i] of `cfg_i`: bit 0 R, bit 1 W, bit 2 X, bits 4:3 match mode (0 off, 1 top-of-range, 2 four-byte word, 3 power-of-two block), bit 7 L. An off entry never matches. A top-of-range entry i covers word addresses from register i-1 (0 for entry 0) inclusive up to register i exclusive. It is valid only if the lower register is strictly below its own.
- R3: Address registers hold byte address bits [ADDR_W-1:2]. Word mode matches exactly that word. Block mode with k trailing ones in the register covers 2^(k+3) bytes aligned to that size.
- R4: When several entries match, only the lowest-numbered one decides the verdict.
- R5: With lockdown clear, a matching locked entry grants only the kinds whose R/W/X bits are set, in every privilege. A matching unlocked entry is enforced that way for supervisor/user and always grants machine mode.
- R6: When no entry matches, supervisor/user faults. Machine mode is granted unless the allowlist flag is set. With lockdown set, a machine fetch also faults.
- R7: With lockdown clear, R=0 W=1 is reserved and grants nothing to any access it is enforced on.
- R8: With lockdown set and the encoding neither R=0 W=1 nor LRWX=1111, an L=1 entry is enforced for machine mode and faults supervisor/user. An L=0 entry is enforced for supervisor/user and faults machine mode.
- R9: With lockdown set, L=0 R=0 W=1 gives machine mode read and write. It gives supervisor/user read, plus write when X=1. It never grants a fetch.
- R10: With lockdown set, L=1 R=0 W=1 gives both privileges fetch, and machine mode read when X=1. It never grants a write.
- R11: With lockdown set, LRWX=1111 grants reads in both privileges and faults every write and fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| addr_i | input | ADDR_W | Request byte address |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| priv_m_i | input | 1 | 1 for machine privilege, 0 for supervisor/user |
| cfg_i | input | 8*NUM_ENT | Packed entry configuration bytes |
| pa_i | input | (ADDR_W-2)*NUM_ENT | Packed entry address registers |
| lockdown_i | input | 1 | Machine lockdown mode |
| allowlist_i | input | 1 | Deny unmatched machine accesses |
| grant_o | output | 1 | Registered verdict, 1 = access allowed |

## Verification
The assertions assume that `acc_i` carries only the three defined access codes. They also assume that every input is held steady from one rising edge to the next, so that the verdict register reflects exactly one request. The bench changes the configuration and the request only on falling edges and never drives code 3. Each request is followed by a sampling point just after the edge that registers it. The scoreboard holds hand-derived expected verdicts in request order, so every verdict is compared against the request that produced it.

// File: rtl/pmpchk_pkg.sv
package pmpchk_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_WORD  = 2'd2,
        MODE_BLOCK = 2'd3
    } match_mode_e;

    localparam int CFG_R   = 0;
    localparam int CFG_W   = 1;
    localparam int CFG_X   = 2;
    localparam int CFG_ALO = 3;
    localparam int CFG_L   = 7;
endpackage

// File: rtl/pmpchk_match.sv
module pmpchk_match
    import pmpchk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] word_i,
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    input  logic [7:0]    cfg_i,
    output logic          match_o
);
    match_mode_e mode;
    logic [AW-1:0] low_ones;

    always_comb begin
        mode     = match_mode_e'(cfg_i[CFG_ALO+1:CFG_ALO]);
        low_ones = hi_i ^ (hi_i + 1'b1);
        unique case (mode)
            MODE_OFF:   match_o = 1'b0;
            MODE_TOR:   match_o = (lo_i < hi_i) && (word_i >= lo_i) && (word_i < hi_i);
            MODE_WORD:  match_o = (word_i == hi_i);
            MODE_BLOCK: match_o = ((word_i & ~low_ones) == (hi_i & ~low_ones));
            default:    match_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmpchk_prio.sv
module pmpchk_prio #(
    parameter int NUM_ENT = 4
) (
    input  logic [NUM_ENT-1:0]   match_i,
    input  logic [NUM_ENT*8-1:0] cfg_i,
    output logic                 hit_o,
    output logic [7:0]           cfg_o
);
    always_comb begin
        hit_o = 1'b0;
        cfg_o = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                hit_o = 1'b1;
                cfg_o = cfg_i[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/pmpchk_perm.sv
module pmpchk_perm
    import pmpchk_pkg::*;
(
    input  logic       hit_i,
    input  logic [7:0] cfg_i,
    input  logic       priv_m_i,
    input  logic [1:0] acc_i,
    input  logic       lockdown_i,
    input  logic       allowlist_i,
    output logic       grant_o
);
    logic r, w, x, l, want_r, want_w, want_x, shared, enforced;

    always_comb begin
        r        = cfg_i[CFG_R];
        w        = cfg_i[CFG_W];
        x        = cfg_i[CFG_X];
        l        = cfg_i[CFG_L];
        want_r   = (acc_e'(acc_i) == ACC_READ);
        want_w   = (acc_e'(acc_i) == ACC_WRITE);
        want_x   = (acc_e'(acc_i) == ACC_FETCH);
        shared   = !r && w;
        enforced = (want_r && r) || (want_w && w) || (want_x && x);
        grant_o  = 1'b0;
        if (!hit_i) begin
            if (priv_m_i) grant_o = !allowlist_i && !(lockdown_i && want_x);
        end else if (!lockdown_i) begin
            if (priv_m_i && !l)   grant_o = 1'b1;
            else if (!shared)     grant_o = enforced;
        end else begin
            if (l && r && w && x)     grant_o = want_r;
            else if (shared && !l)    grant_o = priv_m_i ? (want_r || want_w)
                                                         : (want_r || (want_w && x));
            else if (shared && l)     grant_o = want_x || (priv_m_i && want_r && x);
            else if (l == priv_m_i)   grant_o = enforced;
        end
    end
endmodule

// File: rtl/pmpchk_top.sv
module pmpchk_top
    import pmpchk_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int ADDR_W  = 34
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [1:0]                    acc_i,
    input  logic                          priv_m_i,
    input  logic [NUM_ENT*8-1:0]          cfg_i,
    input  logic [NUM_ENT*(ADDR_W-2)-1:0] pa_i,
    input  logic                          lockdown_i,
    input  logic                          allowlist_i,
    output logic                          grant_o
);
    localparam int AW = ADDR_W - 2;

    logic [AW-1:0]      word;
    logic [NUM_ENT-1:0] match;
    logic               hit;
    logic [7:0]         sel_cfg;
    logic               grant_d;

    assign word = addr_i[ADDR_W-1:2];

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        logic [AW-1:0] lo;
        if (i == 0) begin : g_first
            assign lo = '0;
        end else begin : g_rest
            assign lo = pa_i[AW*(i-1) +: AW];
        end
        pmpchk_match #(.AW(AW)) u_match (
            .word_i  (word),
            .lo_i    (lo),
            .hi_i    (pa_i[AW*i +: AW]),
            .cfg_i   (cfg_i[8*i +: 8]),
            .match_o (match[i])
        );
    end

    pmpchk_prio #(.NUM_ENT(NUM_ENT)) u_prio (
        .match_i (match),
        .cfg_i   (cfg_i),
        .hit_o   (hit),
        .cfg_o   (sel_cfg)
    );

    pmpchk_perm u_perm (
        .hit_i       (hit),
        .cfg_i       (sel_cfg),
        .priv_m_i    (priv_m_i),
        .acc_i       (acc_i),
        .lockdown_i  (lockdown_i),
        .allowlist_i (allowlist_i),
        .grant_o     (grant_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) grant_o <= 1'b0;
        else         grant_o <= grant_d;
    end
endmodule

// File: rtl/pmpchk_sva.sv
module pmpchk_sva (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] acc_i,
    input logic       priv_m_i,
    input logic       lockdown_i,
    input logic       allowlist_i,
    input logic       hit,
    input logic [7:0] sel_cfg,
    input logic       grant_o
);
    logic sh;
    assign sh = !sel_cfg[0] && sel_cfg[1];

    // R5
    a_r5_m_unlocked_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lockdown_i && priv_m_i && hit && !sel_cfg[7]) |=> grant_o);
    // R6
    a_r6_allowlist_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (allowlist_i && priv_m_i && !hit) |=> !grant_o);
    a_r6_lockdown_fetch_nomatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lockdown_i && priv_m_i && acc_i == 2'd2 && !hit) |=> !grant_o);
    // R8
    a_r8_rule_wrong_privilege: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lockdown_i && hit && !sh && !(&{sel_cfg[7], sel_cfg[2:0]})
         && (sel_cfg[7] != priv_m_i)) |=> !grant_o);
    // R9
    a_r9_shared_data_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lockdown_i && hit && sh && !sel_cfg[7] && acc_i == 2'd2) |=> !grant_o);
    // R10
    a_r10_shared_code_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lockdown_i && hit && sh && sel_cfg[7] && acc_i == 2'd1) |=> !grant_o);
    // R11
    a_r11_readonly_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lockdown_i && hit && sel_cfg[7] && sel_cfg[2:0] == 3'b111 && acc_i != 2'd0) |=> !grant_o);
endmodule

bind pmpchk_top pmpchk_sva u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc_i),
    .priv_m_i    (priv_m_i),
    .lockdown_i  (lockdown_i),
    .allowlist_i (allowlist_i),
    .hit         (hit),
    .sel_cfg     (sel_cfg),
    .grant_o     (grant_o)
);

// File: tb/tb_pmpchk_top.sv
module tb_pmpchk_top;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam int AWB = 34;
    localparam int AW = AWB - 2;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic [AWB-1:0] addr_i = '0;
    logic [1:0] acc_i = 2'd0;
    logic priv_m_i = 1'b1;
    logic [NE*8-1:0] cfg_i;
    logic [NE*AW-1:0] pa_i;
    logic lockdown_i = 1'b0;
    logic allowlist_i = 1'b0;
    logic grant_o;

    logic [7:0]    cfg_a [NE];
    logic [AW-1:0] pa_a  [NE];

    typedef struct { bit exp; string tag; } item_t;
    item_t sb_q[$];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    always_comb begin
        for (int i = 0; i < NE; i++) begin
            cfg_i[8*i +: 8]  = cfg_a[i];
            pa_i[AW*i +: AW] = pa_a[i];
        end
    end

    pmpchk_top #(.NUM_ENT(NE), .ADDR_W(AWB)) dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .acc_i(acc_i),
        .priv_m_i(priv_m_i), .cfg_i(cfg_i), .pa_i(pa_i), .lockdown_i(lockdown_i),
        .allowlist_i(allowlist_i), .grant_o(grant_o)
    );

    // monitor: compares one registered verdict per queued item
    always @(posedge clk_i) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (grant_o !== it.exp) begin
                n_fail++;
                $display("FAIL %s: grant_o=%0b expected %0b", it.tag, grant_o, it.exp);
            end
        end
    end

    task automatic set_entry(input int i, input logic [7:0] c, input logic [AW-1:0] p);
        @(negedge clk_i);
        cfg_a[i] = c;
        pa_a[i]  = p;
    endtask

    task automatic clear_all();
        @(negedge clk_i);
        for (int i = 0; i < NE; i++) begin
            cfg_a[i] = 8'h00;
            pa_a[i]  = '0;
        end
    endtask

    task automatic req(input logic [AWB-1:0] a, input logic [1:0] k, input logic m,
                       input bit exp, input string tag);
        item_t it;
        @(negedge clk_i);
        addr_i = a; acc_i = k; priv_m_i = m;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

    initial begin
        fork
            begin
                #(CLK_PERIOD * 200000);
                if (!done) begin
                    n_chk++; n_fail++;
                    $display("FAIL watchdog: run did not finish, expected completion");
                    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                    $finish;
                end
            end
        join_none

        for (int i = 0; i < NE; i++) begin cfg_a[i] = 8'h00; pa_a[i] = '0; end
        // R1: reset holds grant low even with a grantable request
        repeat (3) @(posedge clk_i);
        #1;
        n_chk++;
        if (grant_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: grant_o=%0b expected 0", grant_o);
        end
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R6: no entries configured
        req(34'h100, RD, 1'b1, 1'b1, "R6 M no match granted");
        req(34'h100, RD, 1'b0, 1'b0, "R6 SU no match denied");
        @(negedge clk_i); allowlist_i = 1'b1;
        req(34'h100, RD, 1'b1, 1'b0, "R6 allowlist denies M");
        @(negedge clk_i); allowlist_i = 1'b0;

        // R5 legacy: TOR [0,0x1000) read only unlocked
        set_entry(0, 8'h09, 32'h400);
        req(34'h800, RD, 1'b0, 1'b1, "R5 SU read enforced");
        req(34'h800, WR, 1'b0, 1'b0, "R5 SU write denied");
        req(34'h800, WR, 1'b1, 1'b1, "R5 M unlocked ignored");
        set_entry(0, 8'h89, 32'h400);
        req(34'h800, WR, 1'b1, 1'b0, "R5 M locked write denied");
        req(34'h800, RD, 1'b1, 1'b1, "R5 M locked read granted");

        // R4/R3: word entry 0 inside block entry 1
        clear_all();
        set_entry(0, 8'h10, 32'h800);
        set_entry(1, 8'h1F, 32'h9FF);
        req(34'h2000, RD, 1'b0, 1'b0, "R4 lower entry decides");
        req(34'h2003, RD, 1'b0, 1'b0, "R3 word covers 4 bytes");
        req(34'h2004, RD, 1'b0, 1'b1, "R3 block covers next word");
        req(34'h2FFC, RD, 1'b0, 1'b1, "R3 block top");
        req(34'h3000, RD, 1'b0, 1'b0, "R3 block end exclusive");

        // R2: TOR validity and bounds
        clear_all();
        set_entry(0, 8'h00, 32'h800);
        set_entry(1, 8'h0F, 32'h400);
        req(34'h1000, RD, 1'b0, 1'b0, "R2 invalid TOR no match");
        set_entry(0, 8'h00, 32'h100);
        req(34'h800,  RD, 1'b0, 1'b1, "R2 TOR inside");
        req(34'h400,  RD, 1'b0, 1'b1, "R2 TOR lower inclusive");
        req(34'h1000, RD, 1'b0, 1'b0, "R2 TOR upper exclusive");
        req(34'h3FC,  RD, 1'b0, 1'b0, "R2 TOR below lower");

        // R7: reserved encoding in legacy mode
        clear_all();
        set_entry(0, 8'h0A, 32'h400);
        req(34'h100, WR, 1'b0, 1'b0, "R7 reserved SU write denied");
        req(34'h100, WR, 1'b1, 1'b1, "R7 reserved M unlocked ignored");

        // Lockdown mode
        @(negedge clk_i); lockdown_i = 1'b1;
        set_entry(0, 8'h0F, 32'h400);
        req(34'h100, RD, 1'b1, 1'b0, "R8 SU-only denies M");
        req(34'h100, RD, 1'b0, 1'b1, "R8 SU-only grants SU");
        set_entry(0, 8'h8B, 32'h400);
        req(34'h100, WR, 1'b1, 1'b1, "R8 M-only grants M write");
        req(34'h100, RD, 1'b0, 1'b0, "R8 M-only denies SU");
        req(34'h100, EX, 1'b1, 1'b0, "R8 M-only no X fetch denied");

        set_entry(0, 8'h0A, 32'h400);
        req(34'h100, WR, 1'b1, 1'b1, "R9 shared data M write");
        req(34'h100, WR, 1'b0, 1'b0, "R9 shared data SU write X0");
        req(34'h100, RD, 1'b0, 1'b1, "R9 shared data SU read");
        req(34'h100, EX, 1'b1, 1'b0, "R9 shared data M fetch");
        set_entry(0, 8'h0E, 32'h400);
        req(34'h100, WR, 1'b0, 1'b1, "R9 shared data SU write X1");
        req(34'h100, EX, 1'b0, 1'b0, "R9 shared data SU fetch");

        set_entry(0, 8'h8A, 32'h400);
        req(34'h100, EX, 1'b1, 1'b1, "R10 shared code M fetch");
        req(34'h100, EX, 1'b0, 1'b1, "R10 shared code SU fetch");
        req(34'h100, RD, 1'b1, 1'b0, "R10 shared code M read X0");
        req(34'h100, WR, 1'b1, 1'b0, "R10 shared code M write");
        set_entry(0, 8'h8E, 32'h400);
        req(34'h100, RD, 1'b1, 1'b1, "R10 shared code M read X1");
        req(34'h100, RD, 1'b0, 1'b0, "R10 shared code SU read");
        req(34'h100, WR, 1'b0, 1'b0, "R10 shared code SU write");

        set_entry(0, 8'h8F, 32'h400);
        req(34'h100, RD, 1'b1, 1'b1, "R11 ro M read");
        req(34'h100, RD, 1'b0, 1'b1, "R11 ro SU read");
        req(34'h100, WR, 1'b1, 1'b0, "R11 ro M write");
        req(34'h100, EX, 1'b1, 1'b0, "R11 ro M fetch");
        req(34'h100, EX, 1'b0, 1'b0, "R11 ro SU fetch");

        req(34'h2000, EX, 1'b1, 1'b0, "R6 lockdown M fetch no match");
        req(34'h2000, RD, 1'b1, 1'b1, "R6 lockdown M read no match");

        repeat (3) @(posedge clk_i);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule